// File: doc/BRIEF.md
# Two-Level Short-Descriptor Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level table held in memory. A start pulse delivers the virtual address, the aligned translation table base and a flag that says whether the current translation regime is secure. The walker reads one first-level descriptor. That descriptor either ends the walk (a section mapping or a translation fault) or points at a coarse or fine second-level table, and a second descriptor read then ends the walk.

Reads go out on a simple memory port. A request is offered with valid/ready handshaking and held until it is accepted. Only one read is ever outstanding, and the data returns on a separate response strobe. Every read carries a secure attribute equal to the regime flag sampled at start. When the walk ends, a one-cycle done pulse presents the physical address, the domain, the access permission bits and a fault flag with its code. The walker only extracts the domain and permission bits; it does not check them.

Top module: `sdesc_walker`

## Requirements
- R1: The first read of a walk goes to address {ttb_i[17:0], vaddr_i[31:20], 2'b00}. ttb_i carries base register bits [31:14].
- R2: A request stays asserted with an unchanged address until mem_ready_i is high. At most one read is outstanding, and no new request is raised while a response is pending.
- R3: Every read of a walk drives mem_secure_o equal to the secure_i value captured with the start pulse.
- R4: A first-level descriptor with bits [1:0] = 0 ends the walk with fault_o = 1 and fault_code_o = 5. No second read is issued.
- R5: A first-level descriptor with bits [1:0] = 2 is a section. It ends the walk without a fault and with paddr_o = {desc[31:20], va[19:0]}, ap_o = desc[11:10] and domain_o = desc[8:5]. No second read is issued.
- R6: A first-level descriptor with bits [1:0] = 1 selects a coarse table. The second read then goes to {desc[31:10], va[19:12], 2'b00}.
- R7: A first-level descriptor with bits [1:0] = 3 selects a fine table. The second read then goes to {desc[31:12], va[19:10], 2'b00}.
- R8: A second-level descriptor with bits [1:0] = 1 maps a 64 KB page as {d[31:16], va[15:0]}. A value of 2 maps a 4 KB page as {d[31:12], va[11:0]}. A value of 3 inside a fine table maps a 1 KB page as {d[31:10], va[9:0]}. In all three cases ap_o = d[5:4] and domain_o comes from the first-level descriptor bits [8:5].
- R9: A second-level descriptor with bits [1:0] = 0, or with value 3 inside a coarse table, ends the walk with fault_o = 1 and fault_code_o = 7.
- R10: On any fault, paddr_o and ap_o read zero and domain_o still carries first-level bits [8:5].
- R11: done_o is a one-cycle pulse in the cycle after the response that completes the walk. The result outputs hold their values until the next done pulse.
- R12: start_i is ignored while a walk is in progress. A start in the cycle that done_o is high is accepted and begins a new walk.
- R13: After reset there is no request and no done pulse, and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| ttb_i | input | 18 | Table base, address bits [31:14] |
| secure_i | input | 1 | Current regime is secure |
| done_o | output | 1 | One-cycle completion pulse |
| paddr_o | output | 32 | Translated physical address |
| domain_o | output | 4 | Domain from first-level descriptor |
| ap_o | output | 2 | Access permission bits |
| fault_o | output | 1 | Walk ended in a translation fault |
| fault_code_o | output | 4 | 5 = section fault, 7 = page fault |
| mem_req_o | output | 1 | Descriptor read request valid |
| mem_ready_i | input | 1 | Request accepted |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_secure_o | output | 1 | Secure attribute of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor read data |

## Verification
Two events can fall in the same cycle: the done pulse that finishes one walk and the acceptance of the next start. The bench keeps a queue of pending walks and fires the next start whenever its model is idle, and the model is idle in the very cycle that done is expected. Back-to-back walks therefore overlap a completion with a new start many times. The bench then judges that the finished result matches the model and that, one cycle later, a first-level request appears for the new address. Stray starts driven while a walk is running must leave the request address and the walk's outcome unchanged.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int VA_W     = 32;
    localparam int PA_W     = 32;
    localparam int DESC_W   = 32;
    localparam int DOM_W    = 4;
    localparam int AP_W     = 2;
    localparam int FC_W     = 4;
    localparam int L1_ALIGN = 14;
    localparam int TTB_W    = PA_W - L1_ALIGN;

    localparam logic [FC_W-1:0] FC_SECT_XLAT = 4'd5;
    localparam logic [FC_W-1:0] FC_PAGE_XLAT = 4'd7;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_L1_REQ,
        WS_L1_WAIT,
        WS_L2_REQ,
        WS_L2_WAIT
    } walk_state_e;

    typedef enum logic [1:0] {
        L1_INVALID = 2'd0,
        L1_COARSE  = 2'd1,
        L1_SECTION = 2'd2,
        L1_FINE    = 2'd3
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_INVALID = 2'd0,
        L2_LARGE   = 2'd1,
        L2_SMALL   = 2'd2,
        L2_TINY    = 2'd3
    } l2_kind_e;

    typedef struct packed {
        logic [PA_W-1:0]  pa;
        logic [DOM_W-1:0] domain;
        logic [AP_W-1:0]  ap;
        logic             fault;
        logic [FC_W-1:0]  code;
    } walk_res_t;

    function automatic logic [PA_W-1:0] l1_desc_addr(
        input logic [TTB_W-1:0] ttb,
        input logic [VA_W-1:0]  va
    );
        return {ttb, va[31:20], 2'b00};
    endfunction

    function automatic logic [PA_W-1:0] coarse_desc_addr(
        input logic [DESC_W-1:0] d,
        input logic [VA_W-1:0]   va
    );
        return {d[31:10], va[19:12], 2'b00};
    endfunction

    function automatic logic [PA_W-1:0] fine_desc_addr(
        input logic [DESC_W-1:0] d,
        input logic [VA_W-1:0]   va
    );
        return {d[31:12], va[19:10], 2'b00};
    endfunction

endpackage

// File: rtl/sdw_l1_dec.sv
module sdw_l1_dec
    import sdw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [VA_W-1:0]   va,
    output logic              terminal,
    output logic              next_fine,
    output logic [PA_W-1:0]   next_addr,
    output walk_res_t         res
);

    l1_kind_e kind;
    logic     unused_l1_bits;

    assign kind           = l1_kind_e'(desc[1:0]);
    assign unused_l1_bits = ^{desc[9], desc[4:2]};

    always_comb begin
        res        = '0;
        res.domain = desc[8:5];
        terminal   = 1'b1;
        next_fine  = 1'b0;
        next_addr  = '0;
        case (kind)
            L1_INVALID: begin
                res.fault = 1'b1;
                res.code  = FC_SECT_XLAT;
            end
            L1_SECTION: begin
                res.pa = {desc[31:20], va[19:0]};
                res.ap = desc[11:10];
            end
            L1_COARSE: begin
                terminal  = 1'b0;
                next_addr = coarse_desc_addr(desc, va);
            end
            default: begin
                terminal  = 1'b0;
                next_fine = 1'b1;
                next_addr = fine_desc_addr(desc, va);
            end
        endcase
    end

endmodule

// File: rtl/sdw_l2_dec.sv
module sdw_l2_dec
    import sdw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [15:0]       va_lo,
    input  logic              fine,
    input  logic [DOM_W-1:0]  domain,
    output walk_res_t         res
);

    l2_kind_e kind;
    logic     unused_l2_bits;

    assign kind           = l2_kind_e'(desc[1:0]);
    assign unused_l2_bits = ^{desc[9:6], desc[3:2]};

    always_comb begin
        res        = '0;
        res.domain = domain;
        case (kind)
            L2_LARGE: begin
                res.pa = {desc[31:16], va_lo[15:0]};
                res.ap = desc[5:4];
            end
            L2_SMALL: begin
                res.pa = {desc[31:12], va_lo[11:0]};
                res.ap = desc[5:4];
            end
            L2_TINY: begin
                if (fine) begin
                    res.pa = {desc[31:10], va_lo[9:0]};
                    res.ap = desc[5:4];
                end else begin
                    res.fault = 1'b1;
                    res.code  = FC_PAGE_XLAT;
                end
            end
            default: begin
                res.fault = 1'b1;
                res.code  = FC_PAGE_XLAT;
            end
        endcase
    end

endmodule

// File: rtl/sdesc_walker.sv
module sdesc_walker
    import sdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic [TTB_W-1:0]  ttb_i,
    input  logic              secure_i,
    output logic              done_o,
    output logic [PA_W-1:0]   paddr_o,
    output logic [DOM_W-1:0]  domain_o,
    output logic [AP_W-1:0]   ap_o,
    output logic              fault_o,
    output logic [FC_W-1:0]   fault_code_o,
    output logic              mem_req_o,
    input  logic              mem_ready_i,
    output logic [PA_W-1:0]   mem_addr_o,
    output logic              mem_secure_o,
    input  logic              mem_rvalid_i,
    input  logic [DESC_W-1:0] mem_rdata_i
);

    walk_state_e      st_q;
    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  addr_q;
    logic             sec_q;
    logic             fine_q;
    logic [DOM_W-1:0] dom_q;
    logic             done_q;
    walk_res_t        res_q;

    logic             l1_terminal;
    logic             l1_fine;
    logic [PA_W-1:0]  l1_next_addr;
    walk_res_t        l1_res;
    walk_res_t        l2_res;

    sdw_l1_dec u_l1 (
        .desc      (mem_rdata_i),
        .va        (va_q),
        .terminal  (l1_terminal),
        .next_fine (l1_fine),
        .next_addr (l1_next_addr),
        .res       (l1_res)
    );

    sdw_l2_dec u_l2 (
        .desc   (mem_rdata_i),
        .va_lo  (va_q[15:0]),
        .fine   (fine_q),
        .domain (dom_q),
        .res    (l2_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WS_IDLE;
            va_q   <= '0;
            addr_q <= '0;
            sec_q  <= 1'b0;
            fine_q <= 1'b0;
            dom_q  <= '0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                WS_IDLE: begin
                    if (start_i) begin
                        va_q   <= vaddr_i;
                        sec_q  <= secure_i;
                        addr_q <= l1_desc_addr(ttb_i, vaddr_i);
                        st_q   <= WS_L1_REQ;
                    end
                end
                WS_L1_REQ: begin
                    if (mem_ready_i) st_q <= WS_L1_WAIT;
                end
                WS_L1_WAIT: begin
                    if (mem_rvalid_i) begin
                        if (l1_terminal) begin
                            res_q  <= l1_res;
                            done_q <= 1'b1;
                            st_q   <= WS_IDLE;
                        end else begin
                            addr_q <= l1_next_addr;
                            fine_q <= l1_fine;
                            dom_q  <= l1_res.domain;
                            st_q   <= WS_L2_REQ;
                        end
                    end
                end
                WS_L2_REQ: begin
                    if (mem_ready_i) st_q <= WS_L2_WAIT;
                end
                WS_L2_WAIT: begin
                    if (mem_rvalid_i) begin
                        res_q  <= l2_res;
                        done_q <= 1'b1;
                        st_q   <= WS_IDLE;
                    end
                end
                default: st_q <= WS_IDLE;
            endcase
        end
    end

    assign mem_req_o    = (st_q == WS_L1_REQ) || (st_q == WS_L2_REQ);
    assign mem_addr_o   = addr_q;
    assign mem_secure_o = sec_q;
    assign done_o       = done_q;
    assign paddr_o      = res_q.pa;
    assign domain_o     = res_q.domain;
    assign ap_o         = res_q.ap;
    assign fault_o      = res_q.fault;
    assign fault_code_o = res_q.code;

endmodule

// File: rtl/sdesc_walker_chk.sv
module sdesc_walker_chk
    import sdw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             done_o,
    input logic [PA_W-1:0]  paddr_o,
    input logic [AP_W-1:0]  ap_o,
    input logic             fault_o,
    input logic [FC_W-1:0]  fault_code_o,
    input logic             mem_req_o,
    input logic             mem_ready_i,
    input logic [PA_W-1:0]  mem_addr_o,
    input logic             mem_secure_o,
    input logic             mem_rvalid_i
);

    logic [1:0] outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= '0;
        end else begin
            outstanding <= outstanding
                         + {1'b0, (mem_req_o && mem_ready_i)}
                         - {1'b0, mem_rvalid_i};
        end
    end

    // R2: an unaccepted request is held with the same address
    p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

    // R2: no new request while a read is pending
    p_single_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> outstanding == 2'd0);

    // R2: descriptor reads are word aligned
    p_word_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);

    // R3: secure attribute does not change while a request waits
    p_secure_held_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ready_i |=> $stable(mem_secure_o));

    // R9: fault codes are only the two defined values
    p_fault_code_r9: assert property (@(posedge clk) disable iff (rst)
        done_o && fault_o |-> (fault_code_o == FC_SECT_XLAT || fault_code_o == FC_PAGE_XLAT));

    // R10: faults report zero address and permissions
    p_fault_zero_r10: assert property (@(posedge clk) disable iff (rst)
        done_o && fault_o |-> (paddr_o == '0 && ap_o == '0));

    // R11: done lasts one cycle and never overlaps a request
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_no_req_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_o);

    // R11: done follows a read response
    p_done_after_resp_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(mem_rvalid_i));

endmodule

bind sdesc_walker sdesc_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .done_o       (done_o),
    .paddr_o      (paddr_o),
    .ap_o         (ap_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .mem_req_o    (mem_req_o),
    .mem_ready_i  (mem_ready_i),
    .mem_addr_o   (mem_addr_o),
    .mem_secure_o (mem_secure_o),
    .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/tb_sdesc_walker.sv
module tb_sdesc_walker;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0;
    logic [17:0] ttb = '0;
    logic        secure = 1'b0;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic        done_o, fault_o, mem_req_o, mem_secure_o;
    logic [31:0] paddr_o, mem_addr_o;
    logic [3:0]  domain_o, fault_code_o;
    logic [1:0]  ap_o;

    sdesc_walker dut (
        .clk(clk), .rst(rst), .start_i(start), .vaddr_i(vaddr), .ttb_i(ttb),
        .secure_i(secure), .done_o(done_o), .paddr_o(paddr_o),
        .domain_o(domain_o), .ap_o(ap_o), .fault_o(fault_o),
        .fault_code_o(fault_code_o), .mem_req_o(mem_req_o),
        .mem_ready_i(mem_ready), .mem_addr_o(mem_addr_o),
        .mem_secure_o(mem_secure_o), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit running = 0;

    bit [31:0] mem [bit [31:0]];
    bit [31:0] q_va[$];
    bit [17:0] q_tb[$];
    bit        q_sec[$];

    // behavioural reference state
    int        m_st = 0;        // 0 idle, 1 request, 2 awaiting data
    int        m_lvl = 1;
    int        m_lat = 0;
    bit [31:0] m_addr = 0, m_va = 0;
    bit        m_sec = 0, m_fine = 0, m_done = 0;
    bit [3:0]  m_dom = 0;
    bit [31:0] m_pa = 0;
    bit [3:0]  m_rdom = 0, m_fc = 0;
    bit [1:0]  m_ap = 0;
    bit        m_flt = 0;
    string     m_tag = "R13", m_idle_tag = "R13";
    bit        stray_prev = 0, dc_prev = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic bit [31:0] rd(input bit [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic end_walk(input bit [31:0] pa, input bit [3:0] dm,
                            input bit [1:0] ap, input bit flt,
                            input bit [3:0] fc, input string tag);
        m_pa = pa; m_rdom = dm; m_ap = ap; m_flt = flt; m_fc = fc;
        m_tag = tag; m_idle_tag = tag; m_done = 1; m_st = 0;
    endtask

    always @(negedge clk) begin
        if (running && !finished) begin
            bit [31:0] d;
            // compare against model
            chk(stray_prev ? "R12" : (m_st == 0 ? m_idle_tag : "R2"), "mem_req",
                mem_req_o, m_st == 1);
            if (dc_prev) chk("R12", "request after start in done cycle", mem_req_o, 1);
            if (m_st == 1) begin
                chk(m_lvl == 1 ? "R1" : (m_fine ? "R7" : "R6"), "mem_addr", mem_addr_o, m_addr);
                chk("R3", "mem_secure", mem_secure_o, m_sec);
            end
            chk("R11", "done", done_o, m_done);
            chk(m_flt ? "R10" : m_tag, "paddr", paddr_o, m_pa);
            chk(m_flt ? "R10" : m_tag, "ap", ap_o, m_ap);
            chk(m_tag, "domain", domain_o, m_rdom);
            chk(m_tag, "fault", fault_o, m_flt);
            chk(m_tag, "fault_code", fault_code_o, m_fc);
            stray_prev = 0;
            dc_prev = 0;

            // drive next cycle
            start = 0; mem_ready = 0; mem_rvalid = 0; mem_rdata = $urandom;
            if (m_st == 0) begin
                if (q_va.size() > 0 && ($urandom % 4 != 0 || done_o)) begin
                    m_va = q_va.pop_front();
                    ttb = q_tb.pop_front();
                    m_sec = q_sec.pop_front();
                    vaddr = m_va; secure = m_sec; start = 1;
                    dc_prev = done_o;
                    m_addr = {ttb, m_va[31:20], 2'b00};
                    m_st = 1; m_lvl = 1;
                end
                m_done = 0;
            end else begin
                m_done = 0;
                if ($urandom % 4 == 0) begin
                    start = 1; vaddr = $urandom; ttb = $urandom; secure = $urandom;
                    stray_prev = 1;
                end
                if (m_st == 1) begin
                    if ($urandom % 2) begin
                        mem_ready = 1; m_st = 2; m_lat = $urandom % 3;
                    end
                end else if (m_lat > 0) begin
                    m_lat--;
                end else begin
                    d = rd(m_addr);
                    mem_rvalid = 1; mem_rdata = d;
                    if (m_lvl == 1) begin
                        m_dom = d[8:5];
                        case (d[1:0])
                            2'd0: end_walk(0, d[8:5], 0, 1, 4'd5, "R4");
                            2'd2: end_walk({d[31:20], m_va[19:0]}, d[8:5], d[11:10], 0, 0, "R5");
                            2'd1: begin
                                m_addr = {d[31:10], m_va[19:12], 2'b00};
                                m_fine = 0; m_lvl = 2; m_st = 1;
                            end
                            default: begin
                                m_addr = {d[31:12], m_va[19:10], 2'b00};
                                m_fine = 1; m_lvl = 2; m_st = 1;
                            end
                        endcase
                    end else begin
                        case (d[1:0])
                            2'd0: end_walk(0, m_dom, 0, 1, 4'd7, "R9");
                            2'd1: end_walk({d[31:16], m_va[15:0]}, m_dom, d[5:4], 0, 0, "R8");
                            2'd2: end_walk({d[31:12], m_va[11:0]}, m_dom, d[5:4], 0, 0, "R8");
                            default: begin
                                if (m_fine)
                                    end_walk({d[31:10], m_va[9:0]}, m_dom, d[5:4], 0, 0, "R8");
                                else
                                    end_walk(0, m_dom, 0, 1, 4'd7, "R9");
                            end
                        endcase
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 60; i++) begin
            int        kind = i % 10;
            bit [31:0] tb = 32'h1000_0000 + (i << 20);
            bit [31:0] va = $urandom;
            bit [31:0] r  = $urandom;
            bit [31:0] r2 = $urandom;
            bit [31:0] l2base = 32'h8000_0000 + i * 32'h2000;
            bit [31:0] l1a = {tb[31:14], va[31:20], 2'b00};
            bit [31:0] d1, l2a;
            bit [1:0]  t2;
            case (kind)
                0: d1 = {r[31:2], 2'b00};
                1: d1 = {r[31:2], 2'b10};
                2, 3, 4, 5: d1 = {l2base[31:10], r[9:2], 2'b01};
                default: d1 = {l2base[31:12], r[11:2], 2'b11};
            endcase
            mem[l1a] = d1;
            if (kind >= 2) begin
                if (kind <= 5) l2a = {d1[31:10], va[19:12], 2'b00};
                else           l2a = {d1[31:12], va[19:10], 2'b00};
                case (kind)
                    2, 6: t2 = 2'd1;
                    3, 7: t2 = 2'd2;
                    4, 8: t2 = 2'd3;
                    default: t2 = 2'd0;
                endcase
                mem[l2a] = {r2[31:2], t2};
            end
            q_va.push_back(va);
            q_tb.push_back(tb[31:14]);
            q_sec.push_back(r[0] ^ r2[5]);
        end
        repeat (3) @(posedge clk);
        #5;
        chk("R13", "reset mem_req", mem_req_o, 0);
        chk("R13", "reset done", done_o, 0);
        chk("R13", "reset paddr", paddr_o, 0);
        chk("R13", "reset fault", fault_o, 0);
        rst = 0;
        running = 1;
        wait (q_va.size() == 0 && m_st == 0 && !m_done);
        repeat (5) @(posedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", q_va.size());
            summary();
        end
    end

endmodule